// File: doc/BRIEF.md
# Address-Filtering 9-Bit UART Receiver

This block receives serial frames from a multidrop line where each frame carries a ninth marker bit after eight data bits. A frame with the marker set is an address frame. A frame with the marker clear is a data frame. The receiver keeps a selected/unselected state. A matching address frame selects the node and a non-matching one deselects it. Data frames reach the byte output only while the node is selected. With 9-bit mode off, the marker is ignored and every frame is passed on as data.

The receive clock is the oversampling clock itself, so each cycle is one sample. Software loads the node address and the compare mask with a single configuration write, and that write also turns 9-bit mode off. Mode is then turned back on with a separate write. Two event pulses come out on their own ports: address match and data received. Each event has its own enable, and the enabled events are merged onto one interrupt output.

Top module: `uart9_addr_rx`

## Requirements
- R1: A frame is one low start bit, eight data bits LSB first, the marker bit, and one stop bit, each OSR samples long. If the stop bit is sampled low, `frame_err_o` pulses and the frame is dropped with no output and no event.
- R2: While `mode_o` is 0, every frame is delivered on `data_o` with a one-cycle `data_valid_o` and a `data_rx_o` pulse, whatever its marker. `addr_match_o` never pulses in this mode.
- R3: In 9-bit mode an address frame (marker 1) matches when (byte AND mask) equals (node address AND mask). A match produces a one-cycle `addr_match_o` pulse. With mask 0xFF only the exact address matches.
- R4: After a match, each data frame (marker 0) is delivered on `data_o` with `data_valid_o` and a `data_rx_o` pulse.
- R5: An address frame that does not match deselects the node. Later data frames give no `data_valid_o` and no event until a matching address arrives.
- R6: After reset, and each time 9-bit mode is switched on from off, the node is unselected, so data frames are dropped.
- R7: With `addr_keep_i` at 1, a matching address byte is also delivered on `data_o` with `data_valid_o`, but without `data_rx_o`. With `addr_keep_i` at 0, it is not delivered.
- R8: Reset leaves `mode_o` at 0. A `cfg_wr_i` pulse loads the address and mask and forces `mode_o` to 0. A `mode_wr_i` pulse sets `mode_o` to `mode_val_i`. When both pulse in the same cycle, `cfg_wr_i` wins.
- R9: `irq_o` is high for one cycle, one cycle after an `addr_match_o` pulse with `irq_en_addr_i` set or a `data_rx_o` pulse with `irq_en_data_i` set. A disabled event still pulses its own port. The two events never pulse together.
- R10: Mask bits at 0 are don't-care bits in the address compare. With address 0x30 and mask 0xF0, byte 0x3C matches and byte 0x43 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, one sample per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| cfg_wr_i | input | 1 | Load node address and mask, clears 9-bit mode |
| cfg_addr_i | input | DATA_W | Node address |
| cfg_mask_i | input | DATA_W | Address compare mask |
| mode_wr_i | input | 1 | Write 9-bit mode enable |
| mode_val_i | input | 1 | Value written to the mode enable |
| addr_keep_i | input | 1 | Deliver the matching address byte on the data output |
| irq_en_addr_i | input | 1 | Interrupt enable for the address-match event |
| irq_en_data_i | input | 1 | Interrupt enable for the data-received event |
| data_o | output | DATA_W | Received byte |
| data_valid_o | output | 1 | One-cycle strobe for data_o |
| addr_match_o | output | 1 | Address-match event pulse |
| data_rx_o | output | 1 | Data-received event pulse |
| frame_err_o | output | 1 | Stop-bit error pulse |
| irq_o | output | 1 | Merged interrupt from enabled events |
| mode_o | output | 1 | Current 9-bit mode enable |

## Verification
The bench builds the receiver with OSR = 8 and DATA_W = 8. At that setting a full frame with its idle gap takes about a hundred cycles, which leaves room for many directed frame sequences. Those sequences drive the selected state through every transition: entry from reset, match, mismatch, masked match, and mode switched off and on. Eight-bit bytes let the exact-match and don't-care mask cases be tested with the address values named in the requirements.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP,
    RX_BREAK
  } rx_state_e;
endpackage

// File: rtl/uart9_rx_core.sv
module uart9_rx_core import uart9_pkg::*; #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic              frm_v_o,
  output logic              frm_err_o,
  output logic [DATA_W-1:0] frm_data_o,
  output logic              frm_mark_o
);
  localparam int FRM_W = DATA_W + 1;
  localparam int CNT_W = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int IDX_W = $clog2(FRM_W);
  localparam int HALF  = OSR / 2;

  rx_state_e        st_q;
  logic [1:0]       sync_q;
  logic             rx_s;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [FRM_W-1:0] sh_q;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      frm_v_o   <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      frm_v_o   <= 1'b0;
      frm_err_o <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!rx_s) st_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == CNT_W'(HALF - 1)) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= rx_s ? RX_IDLE : RX_BITS;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_BITS: begin
          if (cnt_q == CNT_W'(OSR - 1)) begin
            cnt_q <= '0;
            sh_q  <= {rx_s, sh_q[FRM_W-1:1]};
            if (idx_q == IDX_W'(FRM_W - 1)) st_q <= RX_STOP;
            else idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_STOP: begin
          if (cnt_q == CNT_W'(OSR - 1)) begin
            cnt_q <= '0;
            if (rx_s) begin
              frm_v_o <= 1'b1;
              st_q    <= RX_IDLE;
            end else begin
              frm_err_o <= 1'b1;
              st_q      <= RX_BREAK;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_BREAK: if (rx_s) st_q <= RX_IDLE;  // wait for line idle after a bad stop
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign frm_data_o = sh_q[DATA_W-1:0];
  assign frm_mark_o = sh_q[FRM_W-1];
endmodule

// File: rtl/uart9_cfg.sv
module uart9_cfg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [DATA_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_mask_i,
  input  logic              mode_wr_i,
  input  logic              mode_val_i,
  output logic [DATA_W-1:0] node_addr_o,
  output logic [DATA_W-1:0] node_mask_o,
  output logic              mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      node_addr_o <= '0;
      node_mask_o <= '1;
      mode_o      <= 1'b0;
    end else if (cfg_wr_i) begin
      node_addr_o <= cfg_addr_i;
      node_mask_o <= cfg_mask_i;
      mode_o      <= 1'b0;
    end else if (mode_wr_i) begin
      mode_o <= mode_val_i;
    end
  end
endmodule

// File: rtl/uart9_filter.sv
module uart9_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_v_i,
  input  logic              frm_err_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic              frm_mark_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] node_addr_i,
  input  logic [DATA_W-1:0] node_mask_i,
  input  logic              addr_keep_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              addr_ev_o,
  output logic              data_ev_o,
  output logic              err_o,
  output logic              sel_o
);
  logic hit;
  assign hit = ((frm_data_i ^ node_addr_i) & node_mask_i) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      valid_o   <= 1'b0;
      addr_ev_o <= 1'b0;
      data_ev_o <= 1'b0;
      err_o     <= 1'b0;
      sel_o     <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      addr_ev_o <= 1'b0;
      data_ev_o <= 1'b0;
      err_o     <= frm_err_i;
      if (!mode_i) sel_o <= 1'b0;  // leaving mode forces unselected on re-entry
      if (frm_v_i) begin
        if (!mode_i) begin
          data_o    <= frm_data_i;
          valid_o   <= 1'b1;
          data_ev_o <= 1'b1;
        end else if (frm_mark_i) begin
          sel_o     <= hit;
          addr_ev_o <= hit;
          if (hit && addr_keep_i) begin
            data_o  <= frm_data_i;
            valid_o <= 1'b1;
          end
        end else if (sel_o) begin
          data_o    <= frm_data_i;
          valid_o   <= 1'b1;
          data_ev_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart9_irq.sv
module uart9_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic addr_ev_i,
  input  logic data_ev_i,
  input  logic en_addr_i,
  input  logic en_data_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= (addr_ev_i & en_addr_i) | (data_ev_i & en_data_i);
  end
endmodule

// File: rtl/uart9_addr_rx.sv
module uart9_addr_rx #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              cfg_wr_i,
  input  logic [DATA_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_mask_i,
  input  logic              mode_wr_i,
  input  logic              mode_val_i,
  input  logic              addr_keep_i,
  input  logic              irq_en_addr_i,
  input  logic              irq_en_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              addr_match_o,
  output logic              data_rx_o,
  output logic              frame_err_o,
  output logic              irq_o,
  output logic              mode_o
);
  logic              frm_v, frm_err, frm_mark, sel;
  logic [DATA_W-1:0] frm_data, node_addr, node_mask;

  uart9_rx_core #(.OSR(OSR), .DATA_W(DATA_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i),
    .frm_v_o(frm_v), .frm_err_o(frm_err),
    .frm_data_o(frm_data), .frm_mark_o(frm_mark)
  );

  uart9_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_mask_i(cfg_mask_i),
    .mode_wr_i(mode_wr_i), .mode_val_i(mode_val_i),
    .node_addr_o(node_addr), .node_mask_o(node_mask), .mode_o(mode_o)
  );

  uart9_filter #(.DATA_W(DATA_W)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .frm_v_i(frm_v), .frm_err_i(frm_err),
    .frm_data_i(frm_data), .frm_mark_i(frm_mark),
    .mode_i(mode_o), .node_addr_i(node_addr), .node_mask_i(node_mask),
    .addr_keep_i(addr_keep_i),
    .data_o(data_o), .valid_o(data_valid_o),
    .addr_ev_o(addr_match_o), .data_ev_o(data_rx_o),
    .err_o(frame_err_o), .sel_o(sel)
  );

  uart9_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_ev_i(addr_match_o), .data_ev_i(data_rx_o),
    .en_addr_i(irq_en_addr_i), .en_data_i(irq_en_data_i),
    .irq_o(irq_o)
  );
endmodule

// File: rtl/uart9_addr_rx_chk.sv
module uart9_addr_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_wr_i,
  input logic irq_en_addr_i,
  input logic irq_en_data_i,
  input logic data_valid_o,
  input logic addr_match_o,
  input logic data_rx_o,
  input logic frame_err_o,
  input logic irq_o,
  input logic mode_o
);
  AST_CFG_CLEARS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> !mode_o);  // R8

  AST_NO_ADDR_EV_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(mode_o) |-> !addr_match_o);  // R2

  AST_DATA_EV_HAS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rx_o |-> data_valid_o);  // R4

  AST_EVENTS_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_match_o && data_rx_o));  // R9

  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past((addr_match_o && irq_en_addr_i) || (data_rx_o && irq_en_data_i)));  // R9

  AST_ERR_NO_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !data_valid_o);  // R1
endmodule

bind uart9_addr_rx uart9_addr_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i),
  .irq_en_addr_i(irq_en_addr_i), .irq_en_data_i(irq_en_data_i),
  .data_valid_o(data_valid_o), .addr_match_o(addr_match_o),
  .data_rx_o(data_rx_o), .frame_err_o(frame_err_o),
  .irq_o(irq_o), .mode_o(mode_o)
);

// File: tb/uart9_addr_rx_bench.sv
module uart9_addr_rx_bench;
  localparam int OSR = 8;
  localparam int DW  = 8;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic cfg_wr = 0, mode_wr = 0, mode_val = 0, keep = 0, en_a = 1, en_d = 1;
  logic [DW-1:0] cfg_addr = '0, cfg_mask = '1;
  logic [DW-1:0] data;
  logic valid, amatch, drx, ferr, irq, mode;

  always #2 clk = ~clk;

  uart9_addr_rx #(.OSR(OSR), .DATA_W(DW)) u_uart9_addr_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_mask_i(cfg_mask),
    .mode_wr_i(mode_wr), .mode_val_i(mode_val), .addr_keep_i(keep),
    .irq_en_addr_i(en_a), .irq_en_data_i(en_d),
    .data_o(data), .data_valid_o(valid), .addr_match_o(amatch),
    .data_rx_o(drx), .frame_err_o(ferr), .irq_o(irq), .mode_o(mode)
  );

  int n_chk = 0, n_bad = 0;
  int c_v = 0, c_a = 0, c_d = 0, c_i = 0, c_e = 0;
  int s_v, s_a, s_d, s_i, s_e;
  logic [DW-1:0] last_d = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (valid)  begin c_v++; last_d = data; end
    if (amatch) c_a++;
    if (drx)    c_d++;
    if (irq)    c_i++;
    if (ferr)   c_e++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic snap();
    s_v = c_v; s_a = c_a; s_d = c_d; s_i = c_i; s_e = c_e;
  endtask

  task automatic hold(input logic b);
    rx = b;
    repeat (OSR) @(negedge clk);
  endtask

  task automatic send(input logic [DW-1:0] d, input logic m, input logic stop);
    snap();
    hold(1'b0);
    for (int i = 0; i < DW; i++) hold(d[i]);
    hold(m);
    hold(stop);
    rx = 1'b1;
    repeat (4 * OSR) @(negedge clk);
  endtask

  task automatic deltas(input string tag, input int v, input int a, input int d, input int q);
    chk(c_v - s_v == v, {tag, " valid"}, c_v - s_v, v);
    chk(c_a - s_a == a, {tag, " addr_ev"}, c_a - s_a, a);
    chk(c_d - s_d == d, {tag, " data_ev"}, c_d - s_d, d);
    chk(c_i - s_i == q, {tag, " irq"}, c_i - s_i, q);
  endtask

  task automatic do_cfg(input logic [DW-1:0] a, input logic [DW-1:0] m);
    @(negedge clk); cfg_addr = a; cfg_mask = m; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic do_mode(input logic v);
    @(negedge clk); mode_val = v; mode_wr = 1;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic t_reset();
    chk(mode == 0, "R8 reset mode", mode, 0);
    chk(valid == 0 && irq == 0, "R8 reset outputs", {valid, irq}, 0);
  endtask

  task automatic t_plain();
    send(8'h5A, 1'b0, 1'b1);
    deltas("R2 plain m0", 1, 0, 1, 1);
    chk(last_d == 8'h5A, "R2 plain byte", last_d, 8'h5A);
    send(8'hC3, 1'b1, 1'b1);
    deltas("R2 plain m1", 1, 0, 1, 1);
    chk(last_d == 8'hC3, "R1 marker after byte", last_d, 8'hC3);
  endtask

  task automatic t_frame_err();
    send(8'h77, 1'b0, 1'b0);
    chk(c_e - s_e == 1, "R1 frame_err", c_e - s_e, 1);
    deltas("R1 err drop", 0, 0, 0, 0);
    send(8'h12, 1'b0, 1'b1);
    chk(last_d == 8'h12 && c_v - s_v == 1, "R1 recover", last_d, 8'h12);
  endtask

  task automatic t_cfg();
    do_mode(1);
    chk(mode == 1, "R8 mode set", mode, 1);
    do_cfg(8'h33, 8'hFF);
    chk(mode == 0, "R8 cfg clears mode", mode, 0);
    @(negedge clk); cfg_wr = 1; mode_wr = 1; mode_val = 1;
    @(negedge clk); cfg_wr = 0; mode_wr = 0;
    chk(mode == 0, "R8 cfg wins", mode, 0);
    do_mode(1);
  endtask

  task automatic t_unaddressed();
    send(8'h55, 1'b0, 1'b1);
    deltas("R6 unselected at entry", 0, 0, 0, 0);
  endtask

  task automatic t_match_data();
    send(8'h33, 1'b1, 1'b1);
    deltas("R3 exact match", 0, 1, 0, 1);
    send(8'hA5, 1'b0, 1'b1);
    deltas("R4 data after match", 1, 0, 1, 1);
    chk(last_d == 8'hA5, "R4 byte", last_d, 8'hA5);
    send(8'h3C, 1'b0, 1'b1);
    chk(last_d == 8'h3C && c_d - s_d == 1, "R4 second byte", last_d, 8'h3C);
  endtask

  task automatic t_mismatch();
    send(8'h32, 1'b1, 1'b1);
    deltas("R3 mask ff one bit off", 0, 0, 0, 0);
    send(8'h99, 1'b0, 1'b1);
    deltas("R5 deselected", 0, 0, 0, 0);
  endtask

  task automatic t_mask();
    do_cfg(8'h30, 8'hF0);
    do_mode(1);
    send(8'h3C, 1'b1, 1'b1);
    deltas("R10 masked hit", 0, 1, 0, 1);
    send(8'h11, 1'b0, 1'b1);
    chk(last_d == 8'h11 && c_v - s_v == 1, "R10 data after masked hit", last_d, 8'h11);
    send(8'h43, 1'b1, 1'b1);
    deltas("R10 masked miss", 0, 0, 0, 0);
    send(8'h22, 1'b0, 1'b1);
    deltas("R5 after masked miss", 0, 0, 0, 0);
  endtask

  task automatic t_keep();
    keep = 1;
    send(8'h35, 1'b1, 1'b1);
    deltas("R7 keep addr", 1, 1, 0, 1);
    chk(last_d == 8'h35, "R7 addr byte", last_d, 8'h35);
    keep = 0;
  endtask

  task automatic t_irq_mask();
    en_d = 0;
    send(8'h66, 1'b0, 1'b1);
    deltas("R9 data irq off", 1, 0, 1, 0);
    en_d = 1; en_a = 0;
    send(8'h31, 1'b1, 1'b1);
    deltas("R9 addr irq off", 0, 1, 0, 0);
    en_a = 1;
  endtask

  task automatic t_reenable();
    do_mode(0);
    do_mode(1);
    send(8'h44, 1'b0, 1'b1);
    deltas("R6 re-enable unselected", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain();
    t_frame_err();
    t_cfg();
    t_unaddressed();
    t_match_data();
    t_mismatch();
    t_mask();
    t_keep();
    t_irq_mask();
    t_reenable();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule